// File: doc/BRIEF.md
# Serial Configuration Write Receiver

This block is a write-only slave on a two-wire serial bus. A bus master sends a start condition, an address byte, two framing bytes whose contents are not used, and then up to one byte for each configuration register. The receiver holds those registers and presents them all at once on a flat output vector to the clock-control logic next to it. The bus lines are sampled with the fast system clock. The receiver sends an acknowledge after each byte by enabling an open-drain pull-down on the data line.

Each data bit is written into its register as soon as the bit has been received. Nothing is staged for a whole byte, so a transfer that ends early leaves the bits that already arrived in place and leaves all other bits unchanged. The master can end a transfer at any bit with a stop condition or a repeated start. It can therefore change only the first few registers and then stop.

Top module: `serial_cfg_rx`

## Requirements
- R1: While no transfer is open, SCL pulses with data on the bus change no register and produce no acknowledge. A transfer opens only when SDA falls while SCL is high (a start condition). When SDA rises while SCL is high, this is a stop condition and it closes the transfer.
- R2: The address byte must equal `SLAVE_ADDR` (default 8'hD2). If it does not, the address gets no acknowledge. Every later byte of that transfer also gets no acknowledge, and no register changes until the next start condition.
- R3: The two bytes after the address are acknowledged, and their values change no register.
- R4: The bytes that follow the two framing bytes go in order into register 0, register 1 and onward, one byte per register. Each byte arrives most significant bit first, and register i appears on `cfg_regs[8*i+7:8*i]`.
- R5: Each bit is written into its own bit position during the SCL low phase that follows the high phase in which the bit was sampled. No holding register is used, so a change in `cfg_regs` alters at most one bit at a time.
- R6: A stop condition or a repeated start can cut a byte short at any bit. Bits already received stay written. Bits not yet reached and later registers keep their earlier values. The extra SCL rise that a repeated start needs writes nothing.
- R7: After each complete byte the receiver pulls SDA low (`sda_oe` = 1) for the whole acknowledge clock. This includes the matching address byte. The pull-down starts after SCL falls and is released on the SCL fall that ends the acknowledge clock.
- R8: After reset the registers hold these values: reg1 = 8'hCF, reg2 = reg3 = 8'hFF, reg5 = 8'h13, reg7 = 8'h07, and reg0 = reg4 = reg6 = 8'h00. `sda_oe` is 0.
- R9: Bytes sent after the last register are acknowledged and then discarded. The byte counter stops at its highest value and does not wrap back to register 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Synchronous reset, active low |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad (wired level) |
| sda_oe | output | 1 | Open-drain enable: 1 pulls SDA low, 0 releases it |
| cfg_regs | output | NUM_REGS*8 | Contents of all registers, register i in bits 8*i+7 down to 8*i |

## Verification
The bench uses the default parameters: eight registers, two framing bytes, address 8'hD2 and a two-stage synchronizer. With only eight registers a transfer of ten data bytes goes past the last register, which brings the counter saturation into the test. The bench also uses a quarter bit time of ten system clocks. This leaves enough margin past the synchronizer delay that the exact SCL phase of every acknowledge, partial write and repeated start can be observed.

// File: rtl/serial_cfg_pkg.sv
// serial_cfg_pkg
// Shared types and reset values for the serial configuration receiver.
// Assumes 8-bit registers. Any register index without a listed default resets to zero.
package serial_cfg_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RECV   = 3'd1,
        ST_ACK_LO = 3'd2,
        ST_ACK_HI = 3'd3,
        ST_HOLD   = 3'd4
    } rx_state_e;

    // Reset value of register idx.
    function automatic logic [BYTE_W-1:0] reset_value(input int idx);
        case (idx)
            1:       reset_value = 8'hCF;
            2, 3:    reset_value = 8'hFF;
            5:       reset_value = 8'h13;
            7:       reset_value = 8'h07;
            default: reset_value = 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/cfg_rx_sync.sv
// cfg_rx_sync
// Brings SCL and SDA into the clk domain through a chain of SYNC_DEPTH flops,
// then finds the SCL edges and the start and stop conditions on the bus.
// Assumes the bus is idle high. SYNC_DEPTH must be at least 2.
module cfg_rx_sync #(
    parameter int SYNC_DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int LINES = 2;   // line 0 = SCL, line 1 = SDA

    logic [LINES-1:0] raw;
    logic [LINES-1:0] sync_q;
    logic [LINES-1:0] prev_q;

    assign raw = {sda_in, scl_in};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [SYNC_DEPTH-1:0] chain;

        // Synchronizer chain for one line, reset to the idle level.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[SYNC_DEPTH-2:0], raw[g]};
        end

        assign sync_q[g] = chain[SYNC_DEPTH-1];

        // One-cycle history of the line, used to find edges.
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q[g] <= 1'b1;
            else        prev_q[g] <= sync_q[g];
        end
    end

    assign sda_s     = sync_q[1];
    assign scl_rise  =  sync_q[0] & ~prev_q[0];
    assign scl_fall  = ~sync_q[0] &  prev_q[0];
    assign start_det =  sync_q[0] &  prev_q[0] &  prev_q[1] & ~sync_q[1];
    assign stop_det  =  sync_q[0] &  prev_q[0] & ~prev_q[1] &  sync_q[1];

endmodule

// File: rtl/cfg_rx_ctrl.sv
// cfg_rx_ctrl
// Protocol sequencer. It checks the address and skips the framing bytes. It
// sends one bit-write strobe for each committed data bit and drives the
// acknowledge. A bit is sampled on SCL rise and written on the next SCL fall,
// so a start or stop inside the high phase discards it.
// Assumes the edge and condition inputs come from cfg_rx_sync.
module cfg_rx_ctrl
    import serial_cfg_pkg::*;
#(
    parameter int           NUM_REGS   = 8,
    parameter int           SKIP_BYTES = 2,
    parameter logic [7:0]   SLAVE_ADDR = 8'hD2,
    localparam int          IDX_W      = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sda_s,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [2:0]       wr_pos,
    output logic             wr_val,
    output logic             sda_oe
);
    localparam int FIRST_DATA = 1 + SKIP_BYTES;
    localparam int LAST_BYTE  = FIRST_DATA + NUM_REGS;
    localparam int CNT_W      = $clog2(LAST_BYTE + 1);

    rx_state_e        state;
    logic [2:0]       bit_cnt;
    logic [CNT_W-1:0] byte_no;
    logic             bit_pend;
    logic             bit_val;
    logic [6:0]       addr_sh;

    logic             commit;
    logic             in_data;
    logic             addr_match;
    logic [CNT_W-1:0] data_off;

    // Decode the commit strobe and where the bit goes.
    always_comb begin
        commit     = (state == ST_RECV) && bit_pend && scl_fall;
        in_data    = (byte_no >= CNT_W'(FIRST_DATA)) && (byte_no < CNT_W'(LAST_BYTE));
        data_off   = byte_no - CNT_W'(FIRST_DATA);
        addr_match = ({addr_sh, bit_val} == SLAVE_ADDR);
        wr_en      = commit && in_data;
        wr_idx     = data_off[IDX_W-1:0];
        wr_pos     = 3'd7 - bit_cnt;
        wr_val     = bit_val;
        sda_oe     = (state == ST_ACK_LO) || (state == ST_ACK_HI);
    end

    // Protocol state, bit and byte counters, and address shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            byte_no  <= '0;
            bit_pend <= 1'b0;
            bit_val  <= 1'b0;
            addr_sh  <= '0;
        end else if (start_det) begin
            state    <= ST_RECV;
            bit_cnt  <= '0;
            byte_no  <= '0;
            bit_pend <= 1'b0;
        end else if (stop_det) begin
            state    <= ST_IDLE;
            bit_pend <= 1'b0;
        end else begin
            case (state)
                ST_RECV: begin
                    if (scl_rise) begin
                        bit_pend <= 1'b1;
                        bit_val  <= sda_s;
                    end else if (commit) begin
                        bit_pend <= 1'b0;
                        if (byte_no == '0) addr_sh <= {addr_sh[5:0], bit_val};
                        if (bit_cnt == 3'd7) begin
                            bit_cnt <= '0;
                            if (byte_no == '0 && !addr_match) state <= ST_HOLD;
                            else                              state <= ST_ACK_LO;
                        end else begin
                            bit_cnt <= bit_cnt + 3'd1;
                        end
                    end
                end
                ST_ACK_LO: begin
                    if (scl_rise) state <= ST_ACK_HI;
                end
                ST_ACK_HI: begin
                    if (scl_fall) begin
                        state <= ST_RECV;
                        if (byte_no != CNT_W'(LAST_BYTE)) byte_no <= byte_no + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/cfg_rx_regs.sv
// cfg_rx_regs
// Bank of NUM_REGS configuration bytes, each written one bit at a time.
// Assumes at most one bit-write strobe per cycle. Reset values come from the package.
module cfg_rx_regs
    import serial_cfg_pkg::*;
#(
    parameter int  NUM_REGS = 8,
    localparam int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [2:0]                 wr_pos,
    input  logic                       wr_val,
    output logic [NUM_REGS*BYTE_W-1:0] cfg_flat
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [BYTE_W-1:0] value;

        // Load the reset value, or update a single addressed bit.
        always_ff @(posedge clk) begin
            if (!rst_n)                                 value         <= reset_value(g);
            else if (wr_en && wr_idx == IDX_W'(g))      value[wr_pos] <= wr_val;
        end

        assign cfg_flat[g*BYTE_W +: BYTE_W] = value;
    end

endmodule

// File: rtl/serial_cfg_rx.sv
// serial_cfg_rx
// Top level of the write-only serial configuration receiver: synchronizer,
// protocol sequencer and register bank. The pad logic outside the block
// drives SDA low whenever sda_oe is 1.
module serial_cfg_rx
    import serial_cfg_pkg::*;
#(
    parameter int         NUM_REGS   = 8,
    parameter int         SKIP_BYTES = 2,
    parameter int         SYNC_DEPTH = 2,
    parameter logic [7:0] SLAVE_ADDR = 8'hD2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       scl_in,
    input  logic                       sda_in,
    output logic                       sda_oe,
    output logic [NUM_REGS*BYTE_W-1:0] cfg_regs
);
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic             sda_s;
    logic             scl_rise;
    logic             scl_fall;
    logic             start_det;
    logic             stop_det;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [2:0]       wr_pos;
    logic             wr_val;

    cfg_rx_sync #(.SYNC_DEPTH(SYNC_DEPTH)) sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    cfg_rx_ctrl #(
        .NUM_REGS   (NUM_REGS),
        .SKIP_BYTES (SKIP_BYTES),
        .SLAVE_ADDR (SLAVE_ADDR)
    ) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_pos    (wr_pos),
        .wr_val    (wr_val),
        .sda_oe    (sda_oe)
    );

    cfg_rx_regs #(.NUM_REGS(NUM_REGS)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_pos   (wr_pos),
        .wr_val   (wr_val),
        .cfg_flat (cfg_regs)
    );

endmodule

// File: rtl/serial_cfg_rx_chk.sv
// serial_cfg_rx_chk
// Assertion checker bound into serial_cfg_rx. It watches the register outputs,
// the acknowledge enable and the strobes passed between the submodules.
module serial_cfg_rx_chk
    import serial_cfg_pkg::*;
#(
    parameter int NUM_REGS = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       sda_oe,
    input logic [NUM_REGS*BYTE_W-1:0] cfg_regs,
    input logic                       scl_fall,
    input logic                       stop_det,
    input logic                       wr_en
);
    // Flat vector of all reset values.
    function automatic logic [NUM_REGS*BYTE_W-1:0] all_defaults();
        logic [NUM_REGS*BYTE_W-1:0] v;
        v = '0;
        for (int i = 0; i < NUM_REGS; i++) v[i*BYTE_W +: BYTE_W] = reset_value(i);
        return v;
    endfunction

    localparam logic [NUM_REGS*BYTE_W-1:0] DEFAULTS = all_defaults();

    // R8: the first cycle out of reset shows the default register values.
    p_defaults_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (cfg_regs == DEFAULTS && !sda_oe));

    // R5: registers change only one cycle after a bit-write strobe.
    p_change_needs_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_regs) |-> $past(wr_en));

    // R5: no more than one bit changes at a time.
    p_single_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cfg_regs ^ $past(cfg_regs)) <= 1);

    // R7: the acknowledge pull-down starts only just after SCL falls.
    p_ack_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> $past(scl_fall));

    // R6: a stop condition releases the data line.
    p_stop_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

endmodule

bind serial_cfg_rx serial_cfg_rx_chk #(.NUM_REGS(NUM_REGS)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .sda_oe   (sda_oe),
    .cfg_regs (cfg_regs),
    .scl_fall (scl_fall),
    .stop_det (stop_det),
    .wr_en    (wr_en)
);

// File: tb/serial_cfg_rx_tb_top.sv
// serial_cfg_rx_tb_top
// Scoreboard bench. Driver tasks run bus transfers, update a model of the
// registers and queue the expected register values. A monitor pops the queue
// at negative clock edges and compares each item with cfg_regs. Acknowledge
// slots are checked directly in the byte task.
module serial_cfg_rx_tb_top;
    localparam int NREG = 8;
    localparam int Q    = 10;   // quarter bit time in clk cycles

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_oe;
    logic [NREG*8-1:0] cfg_regs;
    logic sda_line;

    assign sda_line = m_sda & ~sda_oe;

    always #5 clk = ~clk;

    serial_cfg_rx dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (m_scl),
        .sda_in   (sda_line),
        .sda_oe   (sda_oe),
        .cfg_regs (cfg_regs)
    );

    typedef struct {
        int         idx;
        logic [7:0] val;
        string      req;
    } exp_t;

    exp_t       sb_q[$];
    logic [7:0] model[NREG];
    int         checks = 0;
    int         failures = 0;
    bit         done = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic step();
        repeat (Q) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        m_sda = 1'b1; m_scl = 1'b1; step();
        m_sda = 1'b0; step();
        m_scl = 1'b0; step();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; step();
        m_scl = 1'b1; step();
        m_sda = 1'b1; step();
    endtask

    task automatic bus_restart();
        m_sda = 1'b1; step();
        m_scl = 1'b1; step();
        m_sda = 1'b0; step();
        m_scl = 1'b0; step();
    endtask

    task automatic send_bit(input logic v);
        m_sda = v;    step();
        m_scl = 1'b1; step(); step();
        m_scl = 1'b0; step();
    endtask

    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        m_sda = 1'b1; step();
        m_scl = 1'b1; step();
        check(sda_oe === exp_ack, req, "ack slot", {7'd0, sda_oe}, {7'd0, exp_ack});
        step();
        m_scl = 1'b0; step();
    endtask

    task automatic push_all(input string req);
        for (int i = 0; i < NREG; i++) begin
            exp_t e;
            e.idx = i; e.val = model[i]; e.req = req;
            sb_q.push_back(e);
        end
        wait (sb_q.size() == 0);
    endtask

    // Monitor: compare one queued expectation per falling clock edge.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check(cfg_regs[e.idx*8 +: 8] === e.val, e.req, $sformatf("reg%0d", e.idx),
                  cfg_regs[e.idx*8 +: 8], e.val);
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] data8[NREG];
        data8 = '{8'h3C, 8'hA5, 8'h01, 8'h80, 8'h7E, 8'hC3, 8'h5A, 8'hF0};
        model = '{8'h00, 8'hCF, 8'hFF, 8'hFF, 8'h00, 8'h13, 8'h00, 8'h07};

        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        // R8: reset values and released data line.
        check(sda_oe === 1'b0, "R8", "sda_oe after reset", {7'd0, sda_oe}, 8'd0);
        push_all("R8");

        // R4, R3, R7: full write with nonzero framing bytes.
        bus_start();
        send_byte(8'hD2, 1'b1, "R7");
        send_byte(8'h55, 1'b1, "R3");
        send_byte(8'hAA, 1'b1, "R3");
        for (int i = 0; i < NREG; i++) begin
            send_byte(data8[i], 1'b1, "R7");
            model[i] = data8[i];
        end
        bus_stop();
        push_all("R4");

        // R2: wrong address; nothing acknowledged, nothing written.
        bus_start();
        send_byte(8'hD4, 1'b0, "R2");
        send_byte(8'h00, 1'b0, "R2");
        send_byte(8'h00, 1'b0, "R2");
        send_byte(8'h99, 1'b0, "R2");
        bus_stop();
        bus_start();
        send_byte(8'hD3, 1'b0, "R2");
        send_byte(8'h00, 1'b0, "R2");
        send_byte(8'h00, 1'b0, "R2");
        send_byte(8'h66, 1'b0, "R2");
        bus_stop();
        push_all("R2");

        // R5, R6: four bits of register 0, then stop.
        bus_start();
        send_byte(8'hD2, 1'b1, "R7");
        send_byte(8'h00, 1'b1, "R3");
        send_byte(8'h00, 1'b1, "R3");
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        bus_stop();
        model[0] = {4'b1010, model[0][3:0]};
        push_all("R5");

        // R6: two bits of register 1, restart, then one byte into register 0.
        bus_start();
        send_byte(8'hD2, 1'b1, "R7");
        send_byte(8'h00, 1'b1, "R3");
        send_byte(8'h00, 1'b1, "R3");
        send_byte(8'h11, 1'b1, "R7");
        send_bit(1'b0); send_bit(1'b1);
        bus_restart();
        model[1] = {2'b01, model[1][5:0]};
        send_byte(8'hD2, 1'b1, "R6");
        send_byte(8'h00, 1'b1, "R6");
        send_byte(8'h00, 1'b1, "R6");
        send_byte(8'h22, 1'b1, "R6");
        bus_stop();
        model[0] = 8'h22;
        push_all("R6");

        // R9: ten data bytes; the last two are acknowledged and discarded.
        bus_start();
        send_byte(8'hD2, 1'b1, "R7");
        send_byte(8'h00, 1'b1, "R3");
        send_byte(8'h00, 1'b1, "R3");
        for (int i = 0; i < NREG; i++) begin
            send_byte(~data8[i], 1'b1, "R7");
            model[i] = ~data8[i];
        end
        send_byte(8'hE1, 1'b1, "R9");
        send_byte(8'h1E, 1'b1, "R9");
        bus_stop();
        push_all("R9");

        // R1: SCL pulses with a whole frame but no start condition.
        m_scl = 1'b0; step();
        send_byte(8'hD2, 1'b0, "R1");
        send_byte(8'h00, 1'b0, "R1");
        send_byte(8'h00, 1'b0, "R1");
        send_byte(8'h5A, 1'b0, "R1");
        m_sda = 1'b1; step();
        m_scl = 1'b1; step();
        push_all("R1");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule